// File: doc/BRIEF.md
# Audio Serial Clock Ratio Detector

This block watches the bit clock and the frame sync of a TDM or I2S serial audio input. It does not use them as clocks. It oversamples both lines with a fast free-running reference clock. From the samples it measures two things for every frame: how many bit-clock rising edges fall between two frame-sync rising edges, and how many reference cycles one frame lasts. The first number is mapped onto a fixed set of legal bit-clock-per-frame ratios. The second is sorted into one of six sample-rate buckets, and rates of the 44.1 kHz family fall into the same buckets as their 48 kHz counterparts.

A measurement is reported only after it has repeated on consecutive frames. The reported ratio and rate codes are read-only status. The block then checks three things: that the pair is an allowed combination, that both codes are valid, and that the rate matches the rate setting programmed by the system. Any violation, a frame sync that stops toggling, or the absence of lock raises a ramp-down request to the playback gain stage, so that audio fades out instead of being cut off. A separate flag tells downstream processing to run at half rate when the input arrives in the 192 kHz bucket.

Top module: `aud_clk_ratio_det`

## Requirements
- R1: The bit-clock rising edges counted per frame map to ratio_o codes 0..13 for 16, 24, 32, 48, 64, 96, 128, 192, 256, 384, 512, 125, 250 and 500 respectively. Any other count gives code 15.
- R2: The frame period in reference cycles is classified with a ±2% window around the nominal period of each bucket. rate_o codes are 0..5 for 16, 24, 32, 48, 96 and 192 kHz. The 14.7, 22.05, 29.4, 44.1, 88.2 and 176.4 kHz periods map to the same codes. A period outside every window gives code 7.
- R3: lock_o rises, and ratio_o/rate_o change, only after the same code pair has been measured on 3 consecutive frames. The frame that opens the stream after reset or after a loss is not measured.
- R4: ramp_down_o is high whenever lock_o is low, and also whenever clk_err_o is high.
- R5: While locked, clk_err_o is high for these illegal pairs: ratio 16 at 16 kHz; ratios 384, 512 and 500 at 96 kHz; ratios 256, 384, 512, 250 and 500 at 192 kHz. Ratio 192 and ratio 125 stay legal at 192 kHz.
- R6: While locked, clk_err_o is high when ratio_o is 15 or rate_o is 7.
- R7: While locked, clk_err_o is high when rate_o differs from cfg_rate_i, which uses the rate_o encoding.
- R8: half_rate_o is high exactly when lock_o is high and rate_o is 5.
- R9: If no frame-sync rising edge arrives for more than twice the upper window of the slowest legal frame period, clk_lost_o is set, lock_o falls, and ratio_o/rate_o return to 15/7. clk_lost_o clears when lock is next acquired.
- R10: After reset: lock_o=0, ratio_o=15, rate_o=7, clk_err_o=0, half_rate_o=0, clk_lost_o=0, ramp_down_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock, faster than twice the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock, sampled as data |
| fsync_i | input | 1 | Frame sync, sampled as data |
| cfg_rate_i | input | 3 | Programmed sample-rate code (rate_o encoding) |
| ratio_o | output | 4 | Detected ratio code |
| rate_o | output | 3 | Detected rate code |
| lock_o | output | 1 | Stable clocking detected |
| half_rate_o | output | 1 | Downstream should process at 96 kHz |
| clk_err_o | output | 1 | Illegal or mismatched clocking while locked |
| clk_lost_o | output | 1 | Frame sync timed out since last lock |
| ramp_down_o | output | 1 | Volume ramp-down request |

## Verification
The main function is driven with frames that carry an exact number of bit-clock edges over an exact number of reference cycles. Power-of-two, multiple-of-three and non-binary ratios are used at nominal periods of both rate families, which separates a miscounted edge from a misplaced tolerance window. Pairs on each side of the 16, 96 and 192 kHz exclusions (for example 256 against 384 at 96 kHz, and 125/192 against 250 at 192 kHz) show whether the legality check cuts at the right place. A count of 100 and an off-bucket period make the invalid codes appear. Ratio changes are checked after two and after three new frames to expose a lock that comes too early, and a long frame-sync stall followed by a restart exercises the timeout and the relock.

// File: rtl/acr_pkg.sv
`timescale 1ns/1ps
package acr_pkg;
  localparam int RATIO_N = 14;
  localparam int RATE_N  = 6;
  localparam logic [3:0] RATIO_NONE = 4'hF;
  localparam logic [2:0] RATE_NONE  = 3'd7;
  localparam logic [2:0] RATE_TOP   = 3'd5;

  function automatic int ratio_val(input int idx);
    case (idx)
      0: return 16;   1: return 24;   2: return 32;   3: return 48;
      4: return 64;   5: return 96;   6: return 128;  7: return 192;
      8: return 256;  9: return 384;  10: return 512; 11: return 125;
      12: return 250; 13: return 500;
      default: return 0;
    endcase
  endfunction

  // fam 1 scales the 48k family onto the 44.1k family (147/160)
  function automatic int rate_hz(input int idx, input int fam);
    int base;
    case (idx)
      0: base = 16000;  1: base = 24000; 2: base = 32000;
      3: base = 48000;  4: base = 96000; default: base = 192000;
    endcase
    return (fam != 0) ? base * 147 / 160 : base;
  endfunction

  function automatic int period_nom(input int ref_khz, input int fs_hz);
    longint num;
    num = longint'(ref_khz) * 1000 + longint'(fs_hz / 2);
    return int'(num / longint'(fs_hz));
  endfunction

  function automatic logic pair_legal(input logic [3:0] rc, input logic [2:0] sc);
    if (rc >= 4'(RATIO_N) || sc >= 3'(RATE_N)) return 1'b0;
    case (sc)
      3'd0:    return rc != 4'd0;
      3'd4:    return !(rc inside {4'd9, 4'd10, 4'd13});
      3'd5:    return !(rc inside {4'd8, 4'd9, 4'd10, 4'd12, 4'd13});
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/acr_sync_edge.sv
`timescale 1ns/1ps
module acr_sync_edge #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] rise_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-1:0], din_i[g]};
    end
    assign rise_o[g] = sh_q[STAGES-1] & ~sh_q[STAGES];
  end
endmodule

// File: rtl/acr_frame_meter.sv
`timescale 1ns/1ps
module acr_frame_meter #(
  parameter int CNT_W      = 10,
  parameter int REF_W      = 14,
  parameter int LOST_LIMIT = 13641
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_rise_i,
  input  logic             fsync_rise_i,
  output logic             meas_valid_o,
  output logic [CNT_W-1:0] bits_o,
  output logic [REF_W-1:0] period_o,
  output logic             lost_o
);
  localparam logic [CNT_W-1:0] BIT_MAX = '1;
  localparam logic [REF_W-1:0] REF_MAX = '1;
  localparam logic [REF_W-1:0] LIMIT   = REF_W'(LOST_LIMIT);

  logic [CNT_W-1:0] bit_cnt_q;
  logic [REF_W-1:0] ref_cnt_q;
  logic             have_prev_q, armed_q;

  assign lost_o       = armed_q & ~fsync_rise_i & (ref_cnt_q >= LIMIT);
  assign meas_valid_o = fsync_rise_i & have_prev_q;
  assign bits_o       = bit_cnt_q;
  assign period_o     = ref_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q   <= '0;
      ref_cnt_q   <= '0;
      have_prev_q <= 1'b0;
      armed_q     <= 1'b1;
    end else if (fsync_rise_i) begin
      // an edge coincident with the frame start belongs to the new frame
      bit_cnt_q   <= CNT_W'(bclk_rise_i);
      ref_cnt_q   <= REF_W'(1);
      have_prev_q <= 1'b1;
      armed_q     <= 1'b1;
    end else begin
      if (bclk_rise_i && bit_cnt_q != BIT_MAX) bit_cnt_q <= bit_cnt_q + CNT_W'(1);
      if (ref_cnt_q != REF_MAX)                ref_cnt_q <= ref_cnt_q + REF_W'(1);
      if (lost_o) begin
        have_prev_q <= 1'b0;
        armed_q     <= 1'b0;
      end
    end
  end

  p_lost_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |=> !lost_o);
  p_bits_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fsync_rise_i && !bclk_rise_i) |=> $stable(bit_cnt_q));
endmodule

// File: rtl/acr_ratio_decode.sv
`timescale 1ns/1ps
module acr_ratio_decode
  import acr_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] bits_i,
  output logic [3:0]       code_o
);
  logic [RATIO_N-1:0] hit;

  for (genvar g = 0; g < RATIO_N; g++) begin : g_ratio
    assign hit[g] = (bits_i == CNT_W'(ratio_val(g)));
  end

  always_comb begin
    code_o = RATIO_NONE;
    for (int i = RATIO_N - 1; i >= 0; i--) begin
      if (hit[i]) code_o = 4'(i);
    end
  end

  p_unique_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: rtl/acr_rate_classify.sv
`timescale 1ns/1ps
module acr_rate_classify
  import acr_pkg::*;
#(
  parameter int REF_W   = 14,
  parameter int REF_KHZ = 98304,
  parameter int TOL_PCT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REF_W-1:0] period_i,
  output logic [2:0]       code_o
);
  localparam int WIN_N = 2 * RATE_N;
  logic [WIN_N-1:0] hit;

  for (genvar g = 0; g < WIN_N; g++) begin : g_win
    localparam int NOM = period_nom(REF_KHZ, rate_hz(g % RATE_N, g / RATE_N));
    localparam int LO  = NOM * (100 - TOL_PCT) / 100;
    localparam int HI  = NOM * (100 + TOL_PCT) / 100;
    assign hit[g] = (period_i >= REF_W'(LO)) && (period_i <= REF_W'(HI));
  end

  always_comb begin
    code_o = RATE_NONE;
    for (int i = RATE_N - 1; i >= 0; i--) begin
      if (hit[i] || hit[i+RATE_N]) code_o = 3'(i);
    end
  end

  p_windows_disjoint_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: rtl/aud_clk_ratio_det.sv
`timescale 1ns/1ps
module aud_clk_ratio_det
  import acr_pkg::*;
#(
  parameter int REF_KHZ     = 98304,
  parameter int TOL_PCT     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_FRAMES = 3,
  parameter int CNT_W       = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bclk_i,
  input  logic       fsync_i,
  input  logic [2:0] cfg_rate_i,
  output logic [3:0] ratio_o,
  output logic [2:0] rate_o,
  output logic       lock_o,
  output logic       half_rate_o,
  output logic       clk_err_o,
  output logic       clk_lost_o,
  output logic       ramp_down_o
);
  localparam int SLOW_NOM   = period_nom(REF_KHZ, rate_hz(0, 1));
  localparam int SLOW_HI    = SLOW_NOM * (100 + TOL_PCT) / 100;
  localparam int LOST_LIMIT = 2 * SLOW_HI + 1;
  localparam int REF_W      = $clog2(LOST_LIMIT + 1);
  localparam int MATCH_W    = $clog2(LOCK_FRAMES + 1);
  localparam logic [MATCH_W-1:0] MATCH_TGT = MATCH_W'(LOCK_FRAMES);

  logic [1:0]       rise;
  logic             meas_valid, lost_pulse;
  logic [CNT_W-1:0] bits;
  logic [REF_W-1:0] period;
  logic [3:0]       ratio_code;
  logic [2:0]       rate_code;

  acr_sync_edge #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .din_i({fsync_i, bclk_i}), .rise_o(rise)
  );

  acr_frame_meter #(.CNT_W(CNT_W), .REF_W(REF_W), .LOST_LIMIT(LOST_LIMIT)) u_meter (
    .clk_i, .rst_ni, .bclk_rise_i(rise[0]), .fsync_rise_i(rise[1]),
    .meas_valid_o(meas_valid), .bits_o(bits), .period_o(period), .lost_o(lost_pulse)
  );

  acr_ratio_decode #(.CNT_W(CNT_W)) u_ratio (
    .clk_i, .rst_ni, .bits_i(bits), .code_o(ratio_code)
  );

  acr_rate_classify #(.REF_W(REF_W), .REF_KHZ(REF_KHZ), .TOL_PCT(TOL_PCT)) u_rate (
    .clk_i, .rst_ni, .period_i(period), .code_o(rate_code)
  );

  // agreement filter over consecutive frames
  logic [6:0]         cand, last_q;
  logic [MATCH_W-1:0] match_q, match_nx;
  logic               accept;
  logic [3:0]         ratio_q;
  logic [2:0]         rate_q;
  logic               lock_q, lost_q;

  assign cand = {ratio_code, rate_code};

  always_comb begin
    if (match_q != '0 && cand == last_q)
      match_nx = (match_q < MATCH_TGT) ? match_q + MATCH_W'(1) : match_q;
    else
      match_nx = MATCH_W'(1);
    accept = meas_valid && (match_nx >= MATCH_TGT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= '0;
      match_q <= '0;
      ratio_q <= RATIO_NONE;
      rate_q  <= RATE_NONE;
      lock_q  <= 1'b0;
      lost_q  <= 1'b0;
    end else if (lost_pulse) begin
      match_q <= '0;
      ratio_q <= RATIO_NONE;
      rate_q  <= RATE_NONE;
      lock_q  <= 1'b0;
      lost_q  <= 1'b1;
    end else if (meas_valid) begin
      last_q  <= cand;
      match_q <= match_nx;
      if (accept) begin
        ratio_q <= ratio_code;
        rate_q  <= rate_code;
        lock_q  <= 1'b1;
        lost_q  <= 1'b0;
      end
    end
  end

  assign ratio_o     = ratio_q;
  assign rate_o      = rate_q;
  assign lock_o      = lock_q;
  assign clk_lost_o  = lost_q;
  assign half_rate_o = lock_q && (rate_q == RATE_TOP);
  assign clk_err_o   = lock_q && (!pair_legal(ratio_q, rate_q) || rate_q != cfg_rate_i);
  assign ramp_down_o = !lock_q || clk_err_o;

  p_lock_rise_on_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(meas_valid));
  p_report_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!meas_valid && !lost_pulse) |=> ($stable(ratio_q) && $stable(rate_q)));
  p_lock_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !lost_pulse) |=> lock_q);
  p_lost_unlocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_pulse |=> (!lock_q && ratio_q == RATIO_NONE && rate_q == RATE_NONE));
endmodule

// File: tb/aud_clk_ratio_det_tb.sv
`timescale 1ns/1ps
module aud_clk_ratio_det_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam real REF_HZ    = 98304000.0;

  logic       clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, fsync = 1'b0;
  logic [2:0] cfg = 3'd3;
  logic [3:0] ratio;
  logic [2:0] rate;
  logic       lock, half_rate, clk_err, clk_lost, ramp_down;

  int  checks = 0, fails = 0;
  bit  run = 1'b0, exp_lost = 1'b0, done = 1'b0, prev_ok = 1'b0;
  int  cur_n = 64, cur_p = 2048, frame_starts = 0, prev_n = 0, prev_p = 0;
  int  qn[$], qp[$];
  int  ratio_list[14] = '{16, 24, 32, 48, 64, 96, 128, 192, 256, 384, 512, 125, 250, 500};

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_clk_ratio_det dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .fsync_i(fsync), .cfg_rate_i(cfg),
    .ratio_o(ratio), .rate_o(rate), .lock_o(lock), .half_rate_o(half_rate),
    .clk_err_o(clk_err), .clk_lost_o(clk_lost), .ramp_down_o(ramp_down)
  );

  // frame generator: exactly n bit-clock rises inside p reference cycles
  initial begin
    forever begin
      @(negedge clk);
      if (!run) begin
        fsync = 1'b0; bclk = 1'b0; prev_ok = 1'b0;
      end else begin
        int n, p;
        n = cur_n; p = cur_p;
        if (prev_ok) begin qn.push_back(prev_n); qp.push_back(prev_p); end
        prev_n = n; prev_p = p; prev_ok = 1'b1;
        frame_starts++;
        for (int k = 0; k < p; k++) begin
          if (k > 0) @(negedge clk);
          fsync = (k < p / 2);
          bclk  = ((2 * k * n) / p) % 2;
        end
      end
    end
  end

  function automatic int ratio_code_of(input int n);
    for (int i = 0; i < 14; i++) if (ratio_list[i] == n) return i;
    return 15;
  endfunction

  function automatic int rate_code_of(input int p);
    real bases[6] = '{16000.0, 24000.0, 32000.0, 48000.0, 96000.0, 192000.0};
    for (int i = 0; i < 6; i++) begin
      for (int f = 0; f < 2; f++) begin
        real fs, nom;
        fs  = (f == 0) ? bases[i] : bases[i] * 0.91875;
        nom = REF_HZ / fs;
        if (real'(p) >= nom * 0.98 && real'(p) <= nom * 1.02) return i;
      end
    end
    return 7;
  endfunction

  function automatic bit legal_of(input int rc, input int sc);
    int v;
    if (rc == 15 || sc == 7) return 1'b0;
    v = ratio_list[rc];
    if (sc == 0) return v != 16;
    if (sc == 4) return (v <= 256) || (v == 250);
    if (sc == 5) return v <= 192;
    return 1'b1;
  endfunction

  task automatic model(output bit lk, output int rc, output int sc);
    lk = 1'b0; rc = 15; sc = 7;
    for (int i = 2; i < qn.size(); i++) begin
      int a, b, c;
      a = ratio_code_of(qn[i])   * 8 + rate_code_of(qp[i]);
      b = ratio_code_of(qn[i-1]) * 8 + rate_code_of(qp[i-1]);
      c = ratio_code_of(qn[i-2]) * 8 + rate_code_of(qp[i-2]);
      if (a == b && b == c) begin lk = 1'b1; rc = a / 8; sc = a % 8; end
    end
  endtask

  task automatic cmp(input string req, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, name, act, exp, $time);
    end
  endtask

  // per-clock comparison against the frame-level model
  task automatic check_window(input string req, input int n);
    repeat (n) begin
      bit lk, e_err, e_lost;
      int rc, sc;
      @(posedge clk); #1;
      model(lk, rc, sc);
      e_err  = lk && (!legal_of(rc, sc) || sc != int'(cfg));
      e_lost = exp_lost && !lk;
      cmp(req, "lock_o", lock, lk);
      cmp(req, "ratio_o", ratio, rc);
      cmp(req, "rate_o", rate, sc);
      cmp(req, "half_rate_o", half_rate, lk && sc == 5);
      cmp(req, "clk_err_o", clk_err, e_err);
      cmp(req, "clk_lost_o", clk_lost, e_lost);
      cmp(req, "ramp_down_o", ramp_down, !lk || e_err);
    end
  endtask

  task automatic wait_frames(input int n);
    int t;
    t = frame_starts + n;
    wait (frame_starts >= t);
    repeat (12) @(posedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R10 act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check_window("R10 R4", 3);

    // 48 kHz, ratio 64: no lock after two measured frames, lock after three
    cfg = 3'd3; cur_n = 64; cur_p = 2048; run = 1'b1;
    wait_frames(3); check_window("R3 R4", 3);
    wait_frames(2); check_window("R1 R2", 4);

    // change to non-binary 500: old report held for two frames
    cur_n = 500;
    wait_frames(3); check_window("R3", 3);
    wait_frames(1); check_window("R1 R5", 4);

    // programmed rate mismatch
    @(negedge clk) cfg = 3'd4; repeat (3) @(posedge clk); check_window("R7", 3);
    @(negedge clk) cfg = 3'd3; repeat (3) @(posedge clk); check_window("R7", 3);

    // count outside the list
    cur_n = 100; wait_frames(4); check_window("R6 R1", 4);
    // period outside every window
    cur_n = 64; cur_p = 1500; wait_frames(4); check_window("R6 R2", 4);
    // 44.1 kHz family maps onto the 48 kHz code
    cur_p = 2229; wait_frames(4); check_window("R2", 4);

    // 96 kHz: 384 illegal, 256 legal
    cfg = 3'd4; cur_p = 1024; cur_n = 384; wait_frames(4); check_window("R5", 4);
    cur_n = 256; wait_frames(4); check_window("R5", 4);

    // 192 kHz: 192 legal with half-rate flag, 250 illegal, 125 legal
    cfg = 3'd5; cur_p = 512; cur_n = 192; wait_frames(4); check_window("R8 R5", 4);
    cur_n = 250; wait_frames(4); check_window("R5 R8", 4);
    cur_n = 125; wait_frames(4); check_window("R5 R8", 4);

    // frame sync stall: still locked before the limit, lost after it
    run = 1'b0;
    repeat (5000) @(posedge clk); check_window("R9", 3);
    repeat (9000) @(posedge clk);
    exp_lost = 1'b1; qn.delete(); qp.delete();
    check_window("R9 R4", 4);
    run = 1'b1; wait_frames(3); check_window("R9 R3", 3);
    wait_frames(2); check_window("R9", 4);
    exp_lost = 1'b0;

    // 16 kHz: ratio 16 illegal, 32 legal
    cfg = 3'd0; cur_p = 6144; cur_n = 16; wait_frames(4); check_window("R5", 4);
    cur_n = 32; wait_frames(4); check_window("R5", 4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule